// File: doc/BRIEF.md
# Branch Trace Packet Encoder

This block watches the instruction retirement stream of a single hart and turns it into a compact packet stream. From that stream, host software holding the program image can rebuild the exact execution path. Straight-line code produces no output. Each conditional branch costs one bit. An address is sent only when the next program counter cannot be worked out from the binary: indirect jumps, exceptions and interrupts. Direct jumps, calls and returns are followed by the decoder on its own.

Each cycle the hart presents one retirement record: a valid flag, the instruction's address, its class and the address that executes next. The encoder keeps conditional-branch outcomes in a branch map and writes packets into a small FIFO. The FIFO feeds a valid/ready output. The hart is never stalled. If the FIFO is full when a packet is due, that packet is dropped, a lost flag is raised and the encoder resynchronises with a fresh start packet. An enable input starts and stops tracing.

Top module: `trace_pkt_encoder`

## Requirements
- R1: After reset, `pkt_valid` and `trace_lost` are low and no packet is produced until an enabled, valid retirement arrives.
- R2: The first valid retirement after reset, re-enable or a drop yields a start packet (format 0) whose `pkt_addr0` is that retirement's next address, with count 0 and an empty map. That retirement adds nothing else.
- R3: Retirements of class 0 (sequential) and class 3 (direct jump/call/return) produce no packet.
- R4: A conditional branch (class 1 not taken, class 2 taken) appends one bit to the map, at the index equal to the number of bits already held (bit 0 is the oldest), with 1 meaning taken. When the map would reach MAPW (31) bits, a format 1 packet with count 31 and all bits is produced and the map clears.
- R5: An indirect jump (class 4) yields a format 2 packet that carries the pending count and bits, with `pkt_addr0` set to the target. The map then clears.
- R6: An exception (class 5) or interrupt (class 6) yields a format 3 packet that carries the pending count and bits, with `pkt_addr0` set to the stopped instruction's address and `pkt_addr1` set to the handler target. The map then clears.
- R7: On the first disabled cycle, pending bits are flushed as a format 1 packet. No packet is produced if the map is empty. Retirements are ignored while `trace_en` is low.
- R8: After tracing is re-enabled, the first packet is always a start packet.
- R9: Packets leave in production order. While `pkt_valid` is high and `pkt_ready` is low, the packet is held unchanged.
- R10: A packet that is due while the FIFO holds FIFO_DEPTH entries is dropped and the map clears. `trace_lost` goes high on the next cycle and stays high until a start packet has been queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trace_en | input | 1 | Tracing enabled |
| ret_valid | input | 1 | A retirement record is present |
| ret_class | input | 3 | Class: 0 seq, 1 branch not taken, 2 branch taken, 3 direct jump, 4 indirect jump, 5 exception, 6 interrupt |
| ret_addr | input | AW | Address of the retired instruction |
| ret_next | input | AW | Address executed next |
| pkt_valid | output | 1 | Output packet present |
| pkt_ready | input | 1 | Consumer accepts the packet |
| pkt_fmt | output | 2 | 0 start, 1 branch map, 2 map + target, 3 trap with stop and target |
| pkt_cnt | output | CNTW | Number of valid branch bits |
| pkt_map | output | MAPW | Branch outcome bits, bit 0 oldest |
| pkt_addr0 | output | AW | Start, target or stop address |
| pkt_addr1 | output | AW | Trap target address |
| trace_lost | output | 1 | Packets were dropped since the last start packet |

## Verification
The assertions assume that `ret_class` never takes the unused code 7. They also assume that the address inputs are meaningful only when `ret_valid` is high and that `pkt_ready` does not depend combinationally on the packet outputs. The stimulus draws classes only from the seven defined codes. It drives every input half a cycle away from the clock edge, and it produces ready from its own random draw. Overflow is provoked only deliberately, by holding ready low through a burst of address packets.

// File: rtl/trace_enc_pkg.sv
// Shared encodings for the branch trace encoder.
// Assumes: class codes come from the retirement stage; code 7 is unused.
package trace_enc_pkg;
    typedef enum logic [2:0] {
        RC_SEQ     = 3'd0,
        RC_BR_NT   = 3'd1,
        RC_BR_TK   = 3'd2,
        RC_JMP_DIR = 3'd3,
        RC_JMP_IND = 3'd4,
        RC_EXC     = 3'd5,
        RC_IRQ     = 3'd6
    } ret_class_e;

    typedef enum logic [1:0] {
        FMT_START    = 2'd0,
        FMT_BMAP     = 2'd1,
        FMT_BMAP_TGT = 2'd2,
        FMT_TRAP     = 2'd3
    } pkt_fmt_e;
endpackage

// File: rtl/trace_branch_map.sv
// Branch outcome accumulator: holds up to MAPW taken/not-taken bits.
// Assumes: the controller never pushes while MAPW-1 bits are held
// (it clears instead); clear wins over push.
module trace_branch_map #(
    parameter int MAPW = 31,
    parameter int CNTW = $clog2(MAPW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            taken,
    input  logic            clear,
    output logic [CNTW-1:0] cnt,
    output logic [MAPW-1:0] bits
);
    // Append one outcome bit or clear the whole map.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt  <= '0;
            bits <= '0;
        end else if (push) begin
            bits <= bits | (MAPW'(taken) << cnt);
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/trace_pkt_former.sv
// Packet decision logic: turns one retirement record per cycle into at
// most one packet request, steers the branch map, and tracks the need
// for a start packet and the lost-trace condition.
// Assumes: fifo_full reflects occupancy at the start of the cycle.
module trace_pkt_former
    import trace_enc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int MAPW = 31,
    parameter int CNTW = $clog2(MAPW + 1),
    parameter int PW   = 2 + CNTW + MAPW + 2 * AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trace_en,
    input  logic            ret_valid,
    input  logic [2:0]      ret_class,
    input  logic [AW-1:0]   ret_addr,
    input  logic [AW-1:0]   ret_next,
    input  logic [CNTW-1:0] map_cnt,
    input  logic [MAPW-1:0] map_bits,
    input  logic            fifo_full,
    output logic            map_push,
    output logic            map_taken,
    output logic            map_clear,
    output logic            want,
    output logic            push,
    output logic [PW-1:0]   pkt,
    output logic            need_start,
    output logic            trace_lost
);
    logic            en_q;
    logic            start_pkt;
    logic            drop;
    pkt_fmt_e        fmt;
    logic [CNTW-1:0] p_cnt;
    logic [MAPW-1:0] p_map;
    logic [MAPW-1:0] bits_new;
    logic [AW-1:0]   a0;
    logic [AW-1:0]   a1;
    ret_class_e      cls;

    assign cls       = ret_class_e'(ret_class);
    assign map_taken = (cls == RC_BR_TK);
    assign bits_new  = map_bits | (MAPW'(map_taken) << map_cnt);

    // Decide which packet, if any, this cycle produces.
    always_comb begin
        want      = 1'b0;
        start_pkt = 1'b0;
        map_push  = 1'b0;
        map_clear = 1'b0;
        fmt       = FMT_START;
        p_cnt     = '0;
        p_map     = '0;
        a0        = '0;
        a1        = '0;
        if (!trace_en) begin
            map_clear = 1'b1;
            if (en_q && map_cnt != '0) begin
                want  = 1'b1;
                fmt   = FMT_BMAP;
                p_cnt = map_cnt;
                p_map = map_bits;
            end
        end else if (ret_valid) begin
            if (need_start) begin
                want      = 1'b1;
                start_pkt = 1'b1;
                a0        = ret_next;
            end else begin
                case (cls)
                    RC_BR_NT, RC_BR_TK: begin
                        if (map_cnt == CNTW'(MAPW - 1)) begin
                            want      = 1'b1;
                            fmt       = FMT_BMAP;
                            p_cnt     = CNTW'(MAPW);
                            p_map     = bits_new;
                            map_clear = 1'b1;
                        end else begin
                            map_push = 1'b1;
                        end
                    end
                    RC_JMP_IND: begin
                        want      = 1'b1;
                        fmt       = FMT_BMAP_TGT;
                        p_cnt     = map_cnt;
                        p_map     = map_bits;
                        a0        = ret_next;
                        map_clear = 1'b1;
                    end
                    RC_EXC, RC_IRQ: begin
                        want      = 1'b1;
                        fmt       = FMT_TRAP;
                        p_cnt     = map_cnt;
                        p_map     = map_bits;
                        a0        = ret_addr;
                        a1        = ret_next;
                        map_clear = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
        if (want && fifo_full) begin
            map_clear = 1'b1;
        end
    end

    assign push = want && !fifo_full;
    assign drop = want && fifo_full;
    assign pkt  = {fmt, p_cnt, p_map, a0, a1};

    // Track enable history, pending resync and lost-trace state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            need_start <= 1'b1;
            trace_lost <= 1'b0;
        end else begin
            en_q <= trace_en;
            if (!trace_en || drop) begin
                need_start <= 1'b1;
            end else if (push && start_pkt) begin
                need_start <= 1'b0;
            end
            if (drop) begin
                trace_lost <= 1'b1;
            end else if (push && start_pkt) begin
                trace_lost <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/trace_pkt_fifo.sv
// Synchronous packet FIFO with a valid/ready read side.
// Assumes: DEPTH >= 2; the writer never writes while full.
module trace_pkt_fifo #(
    parameter int PW    = 102,
    parameter int DEPTH = 4,
    parameter int PTRW  = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_data,
    output logic          full,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [PW-1:0] rd_data
);
    logic [PW-1:0]   mem [DEPTH];
    logic [PTRW-1:0] wr_ptr;
    logic [PTRW-1:0] rd_ptr;
    logic [CW-1:0]   count;
    logic            rd_en;

    assign full     = (count == CW'(DEPTH));
    assign rd_valid = (count != '0);
    assign rd_en    = rd_valid && rd_ready;
    assign rd_data  = mem[rd_ptr];

    // Store an incoming packet at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == PTRW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= (rd_ptr == PTRW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end
endmodule

// File: rtl/trace_pkt_encoder.sv
// Branch trace encoder top: branch map, packet decision and output FIFO.
// Assumes: one retirement record per cycle at most; the hart is never
// back-pressured, so output congestion is handled by dropping.
module trace_pkt_encoder #(
    parameter int AW         = 32,
    parameter int MAPW       = 31,
    parameter int FIFO_DEPTH = 4,
    parameter int CNTW       = $clog2(MAPW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trace_en,
    input  logic            ret_valid,
    input  logic [2:0]      ret_class,
    input  logic [AW-1:0]   ret_addr,
    input  logic [AW-1:0]   ret_next,
    output logic            pkt_valid,
    input  logic            pkt_ready,
    output logic [1:0]      pkt_fmt,
    output logic [CNTW-1:0] pkt_cnt,
    output logic [MAPW-1:0] pkt_map,
    output logic [AW-1:0]   pkt_addr0,
    output logic [AW-1:0]   pkt_addr1,
    output logic            trace_lost
);
    localparam int PW = 2 + CNTW + MAPW + 2 * AW;

    logic            map_push;
    logic            map_taken;
    logic            map_clear;
    logic [CNTW-1:0] map_cnt;
    logic [MAPW-1:0] map_bits;
    logic            want;
    logic            push;
    logic            fifo_full;
    logic            need_start;
    logic [PW-1:0]   pkt_in;
    logic [PW-1:0]   pkt_out;

    trace_branch_map #(.MAPW(MAPW), .CNTW(CNTW)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (map_push),
        .taken (map_taken),
        .clear (map_clear),
        .cnt   (map_cnt),
        .bits  (map_bits)
    );

    trace_pkt_former #(.AW(AW), .MAPW(MAPW), .CNTW(CNTW), .PW(PW)) u_former (
        .clk        (clk),
        .rst_n      (rst_n),
        .trace_en   (trace_en),
        .ret_valid  (ret_valid),
        .ret_class  (ret_class),
        .ret_addr   (ret_addr),
        .ret_next   (ret_next),
        .map_cnt    (map_cnt),
        .map_bits   (map_bits),
        .fifo_full  (fifo_full),
        .map_push   (map_push),
        .map_taken  (map_taken),
        .map_clear  (map_clear),
        .want       (want),
        .push       (push),
        .pkt        (pkt_in),
        .need_start (need_start),
        .trace_lost (trace_lost)
    );

    trace_pkt_fifo #(.PW(PW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push),
        .wr_data  (pkt_in),
        .full     (fifo_full),
        .rd_valid (pkt_valid),
        .rd_ready (pkt_ready),
        .rd_data  (pkt_out)
    );

    assign {pkt_fmt, pkt_cnt, pkt_map, pkt_addr0, pkt_addr1} = pkt_out;
endmodule

// File: rtl/trace_enc_checks.sv
// Property checker for trace_pkt_encoder, attached by bind below.
// Assumes: ret_class never carries code 7.
module trace_enc_checks #(
    parameter int AW   = 32,
    parameter int MAPW = 31,
    parameter int CNTW = $clog2(MAPW + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trace_en,
    input logic            ret_valid,
    input logic [2:0]      ret_class,
    input logic            pkt_valid,
    input logic            pkt_ready,
    input logic [1:0]      pkt_fmt,
    input logic [CNTW-1:0] pkt_cnt,
    input logic [MAPW-1:0] pkt_map,
    input logic [AW-1:0]   pkt_addr0,
    input logic [AW-1:0]   pkt_addr1,
    input logic            trace_lost,
    input logic            want,
    input logic            fifo_full,
    input logic            need_start
);
    assert_hold_while_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid &&
        $stable({pkt_fmt, pkt_cnt, pkt_map, pkt_addr0, pkt_addr1}));

    assert_lost_on_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        want && fifo_full |=> trace_lost);

    assert_start_no_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_fmt == 2'd0 |-> pkt_cnt == '0 && pkt_map == '0);

    assert_bmap_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_fmt == 2'd1 |-> pkt_cnt != '0 && pkt_cnt <= CNTW'(MAPW));

    assert_silent_sequential_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trace_en && ret_valid && !need_start &&
        (ret_class == 3'd0 || ret_class == 3'd3) |-> !want);

    assert_restart_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> need_start);
endmodule

bind trace_pkt_encoder trace_enc_checks #(.AW(AW), .MAPW(MAPW), .CNTW(CNTW)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .trace_en   (trace_en),
    .ret_valid  (ret_valid),
    .ret_class  (ret_class),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_fmt    (pkt_fmt),
    .pkt_cnt    (pkt_cnt),
    .pkt_map    (pkt_map),
    .pkt_addr0  (pkt_addr0),
    .pkt_addr1  (pkt_addr1),
    .trace_lost (trace_lost),
    .want       (want),
    .fifo_full  (fifo_full),
    .need_start (need_start)
);

// File: tb/trace_pkt_encoder_bench.sv
// Bench: directed program-flow scenarios plus seeded random traffic,
// compared against a requirement-level reference model.
module trace_pkt_encoder_bench;
    localparam int AW    = 32;
    localparam int MAPW  = 31;
    localparam int DEPTH = 4;
    localparam int CNTW  = $clog2(MAPW + 1);
    localparam int PW    = 2 + CNTW + MAPW + 2 * AW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trace_en = 1'b0;
    logic            ret_valid = 1'b0;
    logic [2:0]      ret_class = 3'd0;
    logic [AW-1:0]   ret_addr = '0;
    logic [AW-1:0]   ret_next = '0;
    logic            pkt_ready = 1'b0;
    logic            pkt_valid;
    logic [1:0]      pkt_fmt;
    logic [CNTW-1:0] pkt_cnt;
    logic [MAPW-1:0] pkt_map;
    logic [AW-1:0]   pkt_addr0;
    logic [AW-1:0]   pkt_addr1;
    logic            trace_lost;

    int checks = 0;
    int fails  = 0;

    logic [PW-1:0] exp_q[$];
    logic [PW-1:0] rec_q[$];

    // reference model state
    logic            m_en_q = 1'b0;
    logic            m_need = 1'b1;
    logic            m_lost = 1'b0;
    int              m_cnt = 0;
    logic [MAPW-1:0] m_map = '0;
    int              occ = 0;

    trace_pkt_encoder #(.AW(AW), .MAPW(MAPW), .FIFO_DEPTH(DEPTH)) u_trace_pkt_encoder (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .ret_valid(ret_valid),
        .ret_class(ret_class), .ret_addr(ret_addr), .ret_next(ret_next),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_fmt(pkt_fmt),
        .pkt_cnt(pkt_cnt), .pkt_map(pkt_map), .pkt_addr0(pkt_addr0),
        .pkt_addr1(pkt_addr1), .trace_lost(trace_lost)
    );

    always #2 clk = ~clk;

    function automatic logic [PW-1:0] mk(input int f, input int c, input logic [MAPW-1:0] m,
                                         input logic [AW-1:0] a0, input logic [AW-1:0] a1);
        return {2'(f), CNTW'(c), m, a0, a1};
    endfunction

    function automatic string tag_of(input logic [PW-1:0] p);
        case (p[PW-1 -: 2])
            2'd0:    return "R2/R8";
            2'd1:    return "R4/R7";
            2'd2:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Reference model: one decision for the coming clock edge.
    task automatic model_step(input logic e, input logic v, input int c,
                              input logic [AW-1:0] a, input logic [AW-1:0] n, input logic r);
        logic            want = 1'b0;
        logic            start = 1'b0;
        logic [PW-1:0]   p = '0;
        int              occ0 = occ;
        if (!e) begin
            if (m_en_q && m_cnt != 0) begin want = 1'b1; p = mk(1, m_cnt, m_map, '0, '0); end
            m_cnt = 0; m_map = '0; m_need = 1'b1;
        end else if (v) begin
            if (m_need) begin
                want = 1'b1; start = 1'b1; p = mk(0, 0, '0, n, '0);
            end else if (c == 1 || c == 2) begin
                m_map = m_map | (MAPW'(c == 2) << m_cnt);
                m_cnt++;
                if (m_cnt == MAPW) begin
                    want = 1'b1; p = mk(1, MAPW, m_map, '0, '0); m_cnt = 0; m_map = '0;
                end
            end else if (c == 4) begin
                want = 1'b1; p = mk(2, m_cnt, m_map, n, '0); m_cnt = 0; m_map = '0;
            end else if (c == 5 || c == 6) begin
                want = 1'b1; p = mk(3, m_cnt, m_map, a, n); m_cnt = 0; m_map = '0;
            end
        end
        m_en_q = e;
        if (want) begin
            if (occ0 < DEPTH) begin
                exp_q.push_back(p);
                occ++;
                if (start) begin m_need = 1'b0; m_lost = 1'b0; end
            end else begin
                m_lost = 1'b1; m_need = 1'b1; m_cnt = 0; m_map = '0;
            end
        end
        if (occ0 > 0 && r) occ--;
    endtask

    // One cycle: check outputs, apply inputs, observe handshake, advance model.
    task automatic cyc(input logic e, input logic v, input int c,
                       input logic [AW-1:0] a, input logic [AW-1:0] n, input logic r);
        logic [PW-1:0] act;
        logic [PW-1:0] exp;
        @(negedge clk);
        check(trace_lost === m_lost, "R10 lost flag", PW'(trace_lost), PW'(m_lost));
        check(pkt_valid === (occ > 0), "R9 valid vs queued", PW'(pkt_valid), PW'(occ > 0));
        trace_en = e; ret_valid = v; ret_class = 3'(c); ret_addr = a; ret_next = n; pkt_ready = r;
        if (pkt_valid && r) begin
            act = {pkt_fmt, pkt_cnt, pkt_map, pkt_addr0, pkt_addr1};
            exp = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
            check(act === exp, tag_of(exp), act, exp);
            rec_q.push_back(act);
        end
        model_step(e, v, c, a, n, r);
    endtask

    task automatic idle(input int k, input logic e);
        for (int i = 0; i < k; i++) cyc(e, 1'b0, 0, '0, '0, 1'b1);
    endtask

    task automatic expect_rec(input int idx, input logic [PW-1:0] exp, input string req);
        logic [PW-1:0] act = (idx < rec_q.size()) ? rec_q[idx] : '1;
        check(act === exp, req, act, exp);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [MAPW-1:0] pat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pkt_valid === 1'b0, "R1 valid after reset", PW'(pkt_valid), '0);
        check(trace_lost === 1'b0, "R1 lost after reset", PW'(trace_lost), '0);
        rst_n = 1'b1;
        idle(3, 1'b1);
        check(pkt_valid === 1'b0, "R1 no packet without retirement", PW'(pkt_valid), '0);

        // factorial-style loop: nt, taken backward, nt; indirect jump; interrupt
        rec_q.delete();
        cyc(1, 1, 0, 32'h100, 32'h104, 1);
        cyc(1, 1, 0, 32'h104, 32'h108, 1);
        cyc(1, 1, 0, 32'h108, 32'h10c, 1);
        cyc(1, 1, 1, 32'h10c, 32'h110, 1);
        cyc(1, 1, 0, 32'h110, 32'h114, 1);
        cyc(1, 1, 0, 32'h114, 32'h118, 1);
        cyc(1, 1, 2, 32'h118, 32'h114, 1);
        cyc(1, 1, 0, 32'h114, 32'h118, 1);
        cyc(1, 1, 1, 32'h118, 32'h11c, 1);
        cyc(1, 1, 3, 32'h11c, 32'h180, 1);
        idle(2, 1'b1);
        check(pkt_valid === 1'b0, "R3 sequential and direct jump silent", PW'(pkt_valid), '0);
        cyc(1, 1, 4, 32'h184, 32'h200, 1);
        cyc(1, 1, 0, 32'h200, 32'h204, 1);
        cyc(1, 1, 6, 32'h204, 32'h400, 1);
        idle(4, 1'b1);
        expect_rec(0, mk(0, 0, '0, 32'h104, '0), "R2 start packet");
        expect_rec(1, mk(2, 3, 31'b010, 32'h200, '0), "R5 indirect with flushed bits");
        expect_rec(2, mk(3, 0, '0, 32'h204, 32'h400), "R6 interrupt stop and target");
        check(PW'(rec_q.size()) === PW'(3), "R3 exact packet count", PW'(rec_q.size()), PW'(3));

        // R4: map fills at 31 bits
        rec_q.delete();
        pat = '0;
        for (int i = 0; i < MAPW; i++) begin
            pat[i] = (i % 3 == 0);
            cyc(1, 1, (i % 3 == 0) ? 2 : 1, 32'h500 + 32'(4 * i), 32'h504 + 32'(4 * i), 1);
        end
        idle(3, 1'b1);
        expect_rec(0, mk(1, MAPW, pat, '0, '0), "R4 full branch map");

        // R6: exception carries pending bits
        rec_q.delete();
        cyc(1, 1, 1, 32'h600, 32'h604, 1);
        cyc(1, 1, 5, 32'h604, 32'h800, 1);
        idle(3, 1'b1);
        expect_rec(0, mk(3, 1, 31'b0, 32'h604, 32'h800), "R6 exception with bit");

        // R7/R8: disable flush, ignored input, restart
        rec_q.delete();
        cyc(1, 1, 2, 32'h900, 32'h920, 1);
        cyc(1, 1, 2, 32'h920, 32'h940, 1);
        cyc(0, 1, 4, 32'h940, 32'h980, 1);
        cyc(0, 1, 5, 32'h980, 32'h990, 1);
        idle(3, 1'b0);
        expect_rec(0, mk(1, 2, 31'b11, '0, '0), "R7 disable flush");
        check(PW'(rec_q.size()) === PW'(1), "R7 disabled input ignored", PW'(rec_q.size()), PW'(1));
        cyc(1, 1, 4, 32'h300, 32'h304, 1);
        idle(3, 1'b1);
        expect_rec(1, mk(0, 0, '0, 32'h304, '0), "R8 restart packet");
        rec_q.delete();
        cyc(0, 0, 0, '0, '0, 1);
        idle(3, 1'b0);
        check(PW'(rec_q.size()) === PW'(0), "R7 empty map no flush", PW'(rec_q.size()), PW'(0));

        // R9/R10: stall output, overflow, resync
        cyc(1, 1, 0, 32'ha00, 32'ha04, 0);
        for (int i = 0; i < DEPTH + 1; i++) cyc(1, 1, 4, 32'ha10, 32'hb00 + 32'(16 * i), 0);
        idle(2, 1'b1);
        check(trace_lost === 1'b1, "R10 lost after overflow", PW'(trace_lost), PW'(1));
        idle(DEPTH, 1'b1);
        cyc(1, 1, 0, 32'hc00, 32'hc04, 1);
        idle(3, 1'b1);
        check(trace_lost === 1'b0, "R10 lost cleared by start", PW'(trace_lost), '0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int  k = int'($urandom % 16);
            int  c = (k <= 8 || k == 15) ? 0 : k - 8;
            logic e = trace_en;
            if (trace_en && ($urandom % 64 == 0)) e = 1'b0;
            else if (!trace_en && ($urandom % 4 == 0)) e = 1'b1;
            cyc(e, ($urandom % 5) != 0, c, 32'($urandom) & ~32'h3, 32'($urandom) & ~32'h3,
                ($urandom % 10) < 7);
        end
        idle(10, 1'b1);
        check(PW'(exp_q.size()) === PW'(0), "R9 all expected packets seen",
              PW'(exp_q.size()), PW'(0));
        summary();
    end
endmodule